// File: doc/BRIEF.md
# Serial Audio Output Port

The block turns parallel stereo sample pairs into a serial data line that follows a bit clock, a left/right clock and, optionally, a word clock. All three are driven from outside and may be gated. The system clock oversamples them, so every step of the port is taken on an edge of the bit clock as seen after resynchronisation. The system-clock period must be well under half a bit-clock period.

Static configuration sets four things: which bit-clock edge the receiver samples on; whether the MSB is held back by one bit; whether fields are framed by the word clock or by the left/right clock; and the field width. A ready/valid load port takes the next sample pair into a one-pair holding slot. That pair is used at the next left-field start. If no pair has arrived by then, the previous pair goes out again and an underflow pulse is raised.

Top module: `ser_audio_tx`

## Requirements
- R1: Each field carries the low W bits of its sample in two's complement, bit W-1 first and bit 0 last. Bits above W-1 on the load bus are ignored.
- R2: The field width W comes from cfg_width. Values from 4 to 24 are used as given, values below 4 act as 4, and values above 24 act as 24.
- R3: With cfg_inv_edge=0 the receiver samples on bit-clock rising edges, and sdata_o changes only after falling edges. With cfg_inv_edge=1 the roles of the two edges are swapped.
- R4: With cfg_lr_trig=1, a field starts at each sampling edge where the left/right clock differs from its value at the previous sampling edge. A high level starts a left field and a low level starts a right field. The word clock has no effect.
- R5: With cfg_lr_trig=0, a field starts at a sampling edge where the word clock is high after being low at the previous sampling edge. The channel is the left/right clock level at that edge (high = left). Changes of the left/right clock alone start nothing, and a word clock held high for several bits starts only one field.
- R6: The MSB is present at the first sampling edge after the one that detected the field start when cfg_msb_dly=0, and at the second when cfg_msb_dly=1.
- R7: Between a field's LSB and the next field's MSB, sdata_o is low. A field may start so that its MSB directly follows the previous LSB. Stopping the bit clock between edges, at either level, does not change the bit sequence.
- R8: ld_ready is high exactly when the holding slot is empty. A pair accepted with ld_valid and ld_ready is sent in the frame whose left field starts next.
- R9: When a left field starts with no new pair, the previous pair is sent again on both channels and uflow_o pulses high for one system-clock cycle. After reset the previous pair is zero.
- R10: A pair accepted in the same system-clock cycle as a left-field start, with the slot empty, is used for that frame, and no underflow is raised.
- R11: During and right after reset, sdata_o is 0, ld_ready is 1 and uflow_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_inv_edge | input | 1 | 0: sampling on bit-clock rise, 1: on fall |
| cfg_msb_dly | input | 1 | Hold the MSB back by one bit |
| cfg_lr_trig | input | 1 | 1: left/right clock frames fields, 0: word clock does |
| cfg_width | input | 5 | Field width in bits (clamped to 4..24) |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External left/right clock, high = left |
| wclk_i | input | 1 | External word clock |
| ld_valid | input | 1 | Sample pair offered |
| ld_ready | output | 1 | Holding slot empty |
| ld_left | input | 24 | Left sample, LSB-justified |
| ld_right | input | 24 | Right sample, LSB-justified |
| sdata_o | output | 1 | Serial data |
| uflow_o | output | 1 | One-cycle pulse when a frame repeats the previous pair |

## Verification
A left-field start and the acceptance of a load can fall in the same system-clock cycle, and the holding slot must then hand the fresh pair straight to the frame. The bench provokes this by sweeping the moment a load is offered, in single-cycle steps, across the sampling edge that opens a left field. Each outcome is judged on the line itself. Either the new pair is sent in that frame with no underflow pulse, or the old pair is repeated with exactly one pulse and the new pair follows in the next frame. Across the sweep both outcomes must occur, and in no case may a pair be lost or duplicated.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // smallest field the port will shift
  localparam int FIELD_MIN = 4;

  typedef enum logic {
    TRIG_WORD = 1'b0,
    TRIG_LR   = 1'b1
  } trig_e;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[STAGES-2:0], a_i[g]};
    end
    assign lvl_o[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/sat_framer.sv
module sat_framer
  import sat_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bk_lvl,
  input  logic  lr_lvl,
  input  logic  wc_lvl,
  input  logic  inv_edge,
  input  trig_e trig,
  output logic  launch_o,
  output logic  start_o,
  output logic  start_left_o
);
  logic bk_prev, lr_prev, wc_prev;
  logic bk_rise, bk_fall, smp;

  always_comb begin
    bk_rise      = bk_lvl & ~bk_prev;
    bk_fall      = ~bk_lvl & bk_prev;
    smp          = inv_edge ? bk_fall : bk_rise;
    launch_o     = inv_edge ? bk_rise : bk_fall;
    start_left_o = lr_lvl;
    if (trig == TRIG_LR) start_o = smp & (lr_lvl ^ lr_prev);
    else                 start_o = smp & wc_lvl & ~wc_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bk_prev <= 1'b0;
      lr_prev <= 1'b0;
      wc_prev <= 1'b0;
    end else begin
      bk_prev <= bk_lvl;
      if (smp) begin
        lr_prev <= lr_lvl;
        wc_prev <= wc_lvl;
      end
    end
  end
endmodule

// File: rtl/sat_pairbuf.sv
module sat_pairbuf #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_left,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [DW-1:0] ld_left,
  input  logic [DW-1:0] ld_right,
  output logic [DW-1:0] word_o,
  output logic          uflow_o
);
  logic          pend_v;
  logic [DW-1:0] pend_l, pend_r, cur_l, cur_r;
  logic          fire, take;

  assign ld_ready = ~pend_v;
  assign fire     = ld_valid & ~pend_v;
  assign take     = start & start_left;

  always_comb begin
    if (!start_left)  word_o = cur_r;
    else if (pend_v)  word_o = pend_l;
    else if (fire)    word_o = ld_left;
    else              word_o = cur_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_l  <= '0;
      pend_r  <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
      uflow_o <= 1'b0;
    end else begin
      uflow_o <= take & ~pend_v & ~fire;
      if (take) begin
        if (pend_v) begin
          cur_l  <= pend_l;
          cur_r  <= pend_r;
          pend_v <= 1'b0;
        end else if (fire) begin
          cur_l <= ld_left;
          cur_r <= ld_right;
        end
      end else if (fire) begin
        pend_l <= ld_left;
        pend_r <= ld_right;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
  import sat_pkg::*;
#(
  parameter int DW = 24,
  parameter int WW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          start,
  input  logic [DW-1:0] word,
  input  logic [WW-1:0] width,
  input  logic          msb_dly,
  output logic          sdata_o
);
  localparam logic [WW-1:0] W_LO = WW'(FIELD_MIN);
  localparam logic [WW-1:0] W_HI = WW'(DW);

  logic [WW-1:0] w_eff;
  logic          arm, arm_dly, busy;
  logic [DW-1:0] arm_word, sh;
  logic [WW-1:0] cnt;

  always_comb begin
    if (width < W_LO)      w_eff = W_LO;
    else if (width > W_HI) w_eff = W_HI;
    else                   w_eff = width;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm      <= 1'b0;
      arm_dly  <= 1'b0;
      arm_word <= '0;
      sh       <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      sdata_o  <= 1'b0;
    end else begin
      if (launch) begin
        if (arm && !arm_dly) begin
          sdata_o <= arm_word[DW-1];
          sh      <= {arm_word[DW-2:0], 1'b0};
          cnt     <= w_eff - 1'b1;
          busy    <= 1'b1;
          arm     <= 1'b0;
        end else begin
          if (arm) arm_dly <= 1'b0;
          if (busy && cnt != '0) begin
            sdata_o <= sh[DW-1];
            sh      <= {sh[DW-2:0], 1'b0};
            cnt     <= cnt - 1'b1;
          end else begin
            sdata_o <= 1'b0;
            busy    <= 1'b0;
          end
        end
      end
      if (start) begin
        arm      <= 1'b1;
        arm_dly  <= msb_dly;
        arm_word <= word << (DW - int'(w_eff));
      end
    end
  end
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import sat_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int WID_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_inv_edge,
  input  logic              cfg_msb_dly,
  input  logic              cfg_lr_trig,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              wclk_i,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W-1:0] ld_left,
  input  logic [DATA_W-1:0] ld_right,
  output logic              sdata_o,
  output logic              uflow_o
);
  logic [2:0]        lvl;
  logic              launch, fr_start, fr_left;
  logic [DATA_W-1:0] fld_word;
  trig_e             trig;

  assign trig = cfg_lr_trig ? TRIG_LR : TRIG_WORD;

  sat_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .a_i({wclk_i, lrclk_i, bclk_i}),
    .lvl_o(lvl)
  );

  sat_framer u_framer (
    .clk(clk), .rst(rst),
    .bk_lvl(lvl[0]), .lr_lvl(lvl[1]), .wc_lvl(lvl[2]),
    .inv_edge(cfg_inv_edge), .trig(trig),
    .launch_o(launch), .start_o(fr_start), .start_left_o(fr_left)
  );

  sat_pairbuf #(.DW(DATA_W)) u_pairbuf (
    .clk(clk), .rst(rst),
    .start(fr_start), .start_left(fr_left),
    .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_left(ld_left), .ld_right(ld_right),
    .word_o(fld_word), .uflow_o(uflow_o)
  );

  sat_shifter #(.DW(DATA_W), .WW(WID_W)) u_shifter (
    .clk(clk), .rst(rst),
    .launch(launch), .start(fr_start),
    .word(fld_word), .width(cfg_width), .msb_dly(cfg_msb_dly),
    .sdata_o(sdata_o)
  );
endmodule

// File: rtl/sat_checker.sv
module sat_checker (
  input logic clk,
  input logic rst,
  input logic launch,
  input logic start,
  input logic start_left,
  input logic lr_trig,
  input logic wc_lvl,
  input logic ld_valid,
  input logic ld_ready,
  input logic sdata,
  input logic uflow
);
  AST_DATA_MOVES_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $past(launch)); // R3
  AST_START_OFF_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    !(start && launch)); // R3
  AST_WORD_MODE_NEEDS_WCLK: assert property (@(posedge clk) disable iff (rst)
    (!lr_trig && start) |-> wc_lvl); // R5
  AST_READY_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!ld_ready && !(start && start_left)) |=> !ld_ready); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && !(start && start_left)) |=> !ld_ready); // R8
  AST_UFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
    uflow |-> $past(start && start_left && ld_ready && !ld_valid)); // R9
  AST_UFLOW_SINGLE: assert property (@(posedge clk) disable iff (rst)
    uflow |=> !uflow); // R9
endmodule

bind ser_audio_tx sat_checker u_chk (
  .clk(clk), .rst(rst), .launch(launch), .start(fr_start),
  .start_left(fr_left), .lr_trig(cfg_lr_trig), .wc_lvl(lvl[2]),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .sdata(sdata_o), .uflow(uflow_o)
);

// File: tb/ser_audio_tx_test.sv
`timescale 1ns/1ps
module ser_audio_tx_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_inv_edge = 0, cfg_msb_dly = 0, cfg_lr_trig = 1;
  logic [4:0] cfg_width = 5'd16;
  logic bclk_i = 1'b1, lrclk_i = 1'b0, wclk_i = 1'b0;
  logic ld_valid = 1'b0;
  logic [23:0] ld_left = '0, ld_right = '0;
  logic ld_ready, sdata_o, uflow_o;

  ser_audio_tx uut (
    .clk(clk), .rst(rst), .cfg_inv_edge(cfg_inv_edge), .cfg_msb_dly(cfg_msb_dly),
    .cfg_lr_trig(cfg_lr_trig), .cfg_width(cfg_width), .bclk_i(bclk_i),
    .lrclk_i(lrclk_i), .wclk_i(wclk_i), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_left(ld_left), .ld_right(ld_right), .sdata_o(sdata_o), .uflow_o(uflow_o)
  );

  int n_chk = 0, n_bad = 0, ucnt = 0;
  int ns, nf, W, vld_slot = -1;
  bit got [0:4095];
  bit inf [0:4095];
  int fst [0:63];
  logic [23:0] fwd [0:63];

  always @(negedge clk) if (!rst && uflow_o) ucnt++;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // one bit slot: launch edge, wait, sample as the receiver would, sampling edge
  task automatic slot(input logic lr, input logic wc);
    bclk_i = cfg_inv_edge; lrclk_i = lr; wclk_i = wc;
    repeat (6) @(negedge clk);
    got[ns] = sdata_o;
    bclk_i = ~cfg_inv_edge; vld_slot = ns;
    repeat (6) @(negedge clk);
    ns++;
  endtask

  task automatic gap_maybe();  // R7: bit clock parked at the sampling level
    if ($urandom % 4 == 0) repeat (1 + $urandom % 20) @(negedge clk);
  endtask

  task automatic field(input logic left, input int n, input logic [23:0] word, input logic hold_wc);
    fst[nf] = ns; fwd[nf] = word; nf++;
    for (int j = 0; j < n; j++) begin
      logic lr, wc;
      lr = left;
      if (cfg_lr_trig) wc = 1'($urandom % 2);
      else begin
        wc = (j == 0) || (j == 1 && hold_wc);
        if (j == n - 1) lr = ~left;
      end
      slot(lr, wc);
      gap_maybe();
    end
  endtask

  task automatic flush();
    for (int j = 0; j < W + 3; j++) slot(1'b0, cfg_lr_trig ? 1'($urandom % 2) : 1'b0);
  endtask

  task automatic load(input logic [23:0] l, input logic [23:0] r);
    ld_left = l; ld_right = r; ld_valid = 1'b1;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_ready == 1'b0, "R8 ready low while a pair is held", ld_ready, 0);
  endtask

  task automatic do_reset(input logic inv, input logic dly, input logic lrm, input logic [4:0] wcfg);
    rst = 1'b1; ld_valid = 1'b0;
    cfg_inv_edge = inv; cfg_msb_dly = dly; cfg_lr_trig = lrm; cfg_width = wcfg;
    bclk_i = ~inv; lrclk_i = 1'b0; wclk_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdata_o == 0 && ld_ready == 1 && uflow_o == 0, "R11 reset state",
        {sdata_o, ld_ready, uflow_o}, 3'b010);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    W = (wcfg < 4) ? 4 : (wcfg > 24) ? 24 : int'(wcfg);
    ns = 0; nf = 0;
  endtask

  task automatic judge();
    logic [23:0] mask, gv;
    int stray;
    mask = (24'h1 << W) - 24'h1;
    for (int s = 0; s < ns; s++) inf[s] = 1'b0;
    for (int f = 0; f < nf; f++) begin
      gv = '0;
      for (int i = 0; i < W; i++) begin
        int idx;
        idx = fst[f] + 1 + int'(cfg_msb_dly) + i;
        gv = {gv[22:0], (idx < ns) ? got[idx] : 1'b0};
        if (idx < ns) inf[idx] = 1'b1;
      end
      chk(gv == (fwd[f] & mask),
          $sformatf("R1 R2 R6 %s %s field %0d W=%0d", cfg_lr_trig ? "R4" : "R5",
                    cfg_inv_edge ? "R3 inverted" : "R3 normal", f, W),
          gv, fwd[f] & mask);
    end
    stray = 0;
    for (int s = 0; s < ns; s++) if (!inf[s] && got[s]) stray++;
    chk(stray == 0, "R7 line low outside fields", stray, 0);
  endtask

  task automatic run(input logic inv, input logic dly, input logic lrm, input logic [4:0] wcfg,
                     input int nfr, input int loadpct);
    logic [23:0] cl, cr;
    int expu, u0;
    do_reset(inv, dly, lrm, wcfg);
    cl = '0; cr = '0; expu = 0; u0 = ucnt;
    slot(1'b0, 1'b0);
    for (int k = 0; k < nfr; k++) begin
      bit ld;
      ld = ($urandom % 100) < loadpct;
      if (ld) begin
        cl = 24'($urandom); cr = 24'($urandom);
        load(cl, cr);
      end else expu++;
      field(1'b1, W + int'($urandom % 4), cl, 1'($urandom % 2));
      if (ld) chk(ld_ready == 1'b1, "R8 ready back after left start", ld_ready, 1);
      field(1'b0, W + int'($urandom % 4), cr, 1'($urandom % 2));
    end
    flush();
    judge();
    chk(ucnt - u0 == expu, "R9 underflow pulse count", ucnt - u0, expu);
  endtask

  int direct_hits = 0, late_hits = 0;

  task automatic sweep(input int off);  // R10: load offered around a left start
    logic [23:0] p0l, p0r, p1l, p1r;
    int u0, ub, bstart;
    do_reset(1'b0, 1'b0, 1'b1, 5'd8);
    p0l = 24'($urandom); p0r = 24'($urandom); p1l = 24'($urandom); p1r = 24'($urandom);
    slot(1'b0, 1'b0);
    load(p0l, p0r);
    field(1'b1, 8, p0l, 1'b0);
    field(1'b0, 8, p0r, 1'b0);
    u0 = ucnt; bstart = ns;
    fork
      field(1'b1, 8, '0, 1'b0);
      begin
        wait (vld_slot == bstart);
        repeat (off) @(negedge clk);
        ld_left = p1l; ld_right = p1r; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
      end
    join
    ub = ucnt - u0;
    field(1'b0, 8, '0, 1'b0);
    field(1'b1, 8, '0, 1'b0);
    field(1'b0, 8, '0, 1'b0);
    flush();
    if (ub == 1) begin
      late_hits++; fwd[2] = p0l; fwd[3] = p0r;
    end else begin
      direct_hits++; fwd[2] = p1l; fwd[3] = p1r;
    end
    fwd[4] = p1l; fwd[5] = p1r;
    judge();
    chk(ucnt - u0 == 1, $sformatf("R10 one underflow across frames, offset %0d", off), ucnt - u0, 1);
  endtask

  initial begin
    void'($urandom(32'd1931));
    @(negedge clk);
    run(1'b0, 1'b0, 1'b1, 5'd16, 6, 80);
    run(1'b1, 1'b0, 1'b1, 5'd24, 5, 80);
    run(1'b0, 1'b1, 1'b1, 5'd8,  6, 70);
    run(1'b1, 1'b1, 1'b0, 5'd12, 6, 80);
    run(1'b0, 1'b0, 1'b0, 5'd4,  6, 60);
    run(1'b0, 1'b1, 1'b0, 5'd20, 4, 100);
    run(1'b1, 1'b0, 1'b0, 5'd2,  4, 100);  // R2 clamp low
    run(1'b0, 1'b0, 1'b1, 5'd31, 3, 100);  // R2 clamp high
    run(1'b1, 1'b1, 1'b1, 5'd4,  6, 50);
    for (int off = 0; off < 5; off++) sweep(off);
    chk(direct_hits > 0 && late_hits > 0, "R10 both outcomes seen in sweep",
        {direct_hits[15:0], late_hits[15:0]}, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule